// File: doc/BRIEF.md
# SPI Host Register and FIFO Front End

This block is the software-facing side of a SPI host. A processor reaches it through a simple 32-bit register read/write port. Through that port it sets the controller configuration, describes the next frame (byte counts, idle cycles, lane flags), enables interrupts and reads or clears status. A separate serial frame engine, not part of this block, does the shifting. The engine takes transmit bytes from one FIFO, puts received bytes into the other, and reports done events and readiness back.

Each FIFO has two data registers. One moves a single byte in bits 7:0. The other moves four bytes in one access, and the oldest byte sits in bits 7:0. A control flag selects which of the two is live. Done and available events stay set until software writes 1 to them. The interrupt line is the OR of the status bits that are also enabled. Writing the frames register starts a new frame: it flushes both FIFOs and sends a one-cycle start pulse to the engine.

Top module: `spi_host_regfront`

## Requirements
- R1: After reset the control, frames, upper-count and interrupt-enable registers read 0. Both FIFOs are empty and `irq` is low. The status register then reads 0x90 when `engineReady` is 1, which means receive-empty (bit 4) and ready (bit 7).
- R2: The control register at 0x00 stores only bits 0-3, 10-16 and 24-27 (write mask 0x0F01FC0F) and reads back the stored value. Bit 0 drives `cfgEnable`, bit 1 `cfgHost`, bit 13 `cfgWideSel`, bits 15:14 `cfgLaneMode` and bits 27:24 `cfgClkDiv`.
- R3: The frames register at 0x04 drives `cfgTotalBytes[15:0]` from bits 15:0, `cfgCmdBytes` from 24:16, `cfgMultiLane` from 25, `cfgIdleCycles` from 29:26 and `cfgFrameFlags` from 31:30. The register at 0x50 keeps bits 31:16, which form `cfgTotalBytes[31:16]`. A frames write raises `frameStart` for exactly one cycle, in the cycle after the write.
- R4: With control bit 16 clear, each write to 0x44 queues bits 7:0 of the write data for the engine. `txByte`/`txValid` present the bytes in write order, and a byte leaves when `txReady` is high.
- R5: With control bit 16 set, a write to 0x4C queues four bytes, bits 7:0 first and bits 31:24 last. If fewer than four slots are free, the whole write is dropped.
- R6: With control bit 16 clear, a read of 0x40 returns the oldest received byte in bits 7:0 with zeros above, and removes it. A read of an empty receive FIFO returns 0 and removes nothing.
- R7: With control bit 16 set, a read of 0x48 returns the four oldest received bytes, oldest in bits 7:0, and removes them. With fewer than four bytes held it returns 0 and removes nothing.
- R8: An access to the data register of the mode that is not selected by control bit 16 has no effect: a write queues nothing and a read returns 0 and removes nothing.
- R9: Each FIFO holds 16 bytes. A transmit write into a full FIFO is dropped, and a received byte offered while the receive FIFO is full is dropped.
- R10: Status bits 0 (transmit done, from `txDoneIn`), 1 (receive done, from `rxDoneIn`), 2 (receive available: a byte entered the receive FIFO) and 3 (transmit available: the engine took a byte) are sticky. Writing 1 to them at 0x10 clears them. A set event in the same cycle as the clear wins.
- R11: Status bit 4 shows the receive FIFO empty, bit 5 the transmit FIFO full, bit 7 the `engineReady` input and bit 8 control bit 16.
- R12: The interrupt-enable register at 0x0C holds 6 bits. `irq` is high exactly when some status bit 0-5 is set together with its enable bit.
- R13: A frames-register write empties both FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops on the clock edge) |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the cycle of `regRdEn` |
| txByte | output | 8 | Oldest transmit byte |
| txValid | output | 1 | Transmit FIFO not empty |
| txReady | input | 1 | Engine takes `txByte` this cycle |
| rxByte | input | 8 | Received byte from the engine |
| rxValid | input | 1 | `rxByte` is offered this cycle |
| txDoneIn | input | 1 | Engine transmit-done event |
| rxDoneIn | input | 1 | Engine receive-done event |
| engineReady | input | 1 | Engine idle and ready |
| cfgEnable | output | 1 | Core enable |
| cfgHost | output | 1 | Host mode select |
| cfgClkDiv | output | 4 | Serial clock divider |
| cfgLaneMode | output | 2 | Lane usage mode |
| cfgWideSel | output | 1 | Two- or four-lane select |
| cfgTotalBytes | output | 32 | Total bytes in the frame |
| cfgCmdBytes | output | 9 | Command bytes in the frame |
| cfgMultiLane | output | 1 | Multi-lane frame flag |
| cfgIdleCycles | output | 4 | Idle cycles before data |
| cfgFrameFlags | output | 2 | Byte/word flag pair |
| frameStart | output | 1 | One-cycle pulse after a frames write |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the FIFO edges. A four-byte write with only two free slots must be dropped whole. A design that queued a partial word would hand the engine stray bytes ahead of the ones written later. The bench also sends a seventeenth received byte into a full FIFO. A design that wrapped its pointer would overwrite the oldest byte and return the data out of order.

Quad and byte reads of too-short or empty FIFOs must return 0 and leave the data in place. A design that popped anyway would lose bytes that a later byte-mode read expects. Data-register accesses in the mode that is not selected are checked at the engine outputs and on a later read. A write-1-to-clear that arrives in the same cycle as a new done event must leave the bit set; a design with clear priority would lose that event and never raise `irq`.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_FRAMES = 8'h04;
  localparam logic [7:0] OFS_IEN    = 8'h0C;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_RXB    = 8'h40;
  localparam logic [7:0] OFS_TXB    = 8'h44;
  localparam logic [7:0] OFS_RXW    = 8'h48;
  localparam logic [7:0] OFS_TXW    = 8'h4C;
  localparam logic [7:0] OFS_UPPER  = 8'h50;

  localparam logic [31:0] CTRL_WMASK = 32'h0F01_FC0F;
  localparam int          QUAD_BIT   = 16;
  localparam int          IEN_W      = 6;
  localparam int          STICKY_W   = 4;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_FRAMES,
    RD_IEN,
    RD_STATUS,
    RD_UPPER,
    RD_RXB,
    RD_RXW
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrFrames;
    logic   wrIen;
    logic   wrStatus;
    logic   wrUpper;
    logic   txPush1;
    logic   txPush4;
    logic   txPop;
    logic   rxPush;
    logic   rxPop1;
    logic   rxPop4;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/spi_regfront_fifo.sv
module spi_regfront_fifo #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [2:0]       pushN,
  input  logic [31:0]      pushData,
  input  logic [2:0]       popN,
  output logic [31:0]      headWord,
  output logic [LVL_W-1:0] level
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  // Four-byte window starting at the oldest entry, oldest in the low byte.
  for (genvar g = 0; g < 4; g++) begin : g_peek
    assign headWord[8*g +: 8] = mem[rdPtr + PTR_W'(g)];
  end

  always_ff @(posedge clk) begin
    if (!flush) begin
      for (int i = 0; i < 4; i++) begin
        if (3'(i) < pushN) mem[wrPtr + PTR_W'(i)] <= pushData[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(pushN);
      rdPtr <= rdPtr + PTR_W'(popN);
      level <= level + LVL_W'(pushN) - LVL_W'(popN);
    end
  end

endmodule

// File: rtl/spi_regfront_ctrl.sv
module spi_regfront_ctrl
  import spi_regfront_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [7:0]       regAddr,
  input  logic             quadMode,
  input  logic             txReady,
  input  logic             rxValid,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  output strobes_t         stb
);

  localparam logic [LVL_W-1:0] LVL_FULL  = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LVL_ROOM4 = LVL_W'(DEPTH - 4);
  localparam logic [LVL_W-1:0] LVL_FOUR  = LVL_W'(4);

  logic txHasByte;
  logic txHasRoom1;
  logic txHasRoom4;
  logic rxHasByte;
  logic rxHasWord;
  logic rxHasRoom;

  always_comb begin
    txHasByte  = (txLevel != '0);
    txHasRoom1 = (txLevel < LVL_FULL);
    txHasRoom4 = (txLevel <= LVL_ROOM4);
    rxHasByte  = (rxLevel != '0);
    rxHasWord  = (rxLevel >= LVL_FOUR);
    rxHasRoom  = (rxLevel < LVL_FULL);
  end

  always_comb begin
    stb          = '0;
    stb.rdSel    = RD_NONE;
    stb.wrCtrl   = regWrEn && (regAddr == OFS_CTRL);
    stb.wrFrames = regWrEn && (regAddr == OFS_FRAMES);
    stb.wrIen    = regWrEn && (regAddr == OFS_IEN);
    stb.wrStatus = regWrEn && (regAddr == OFS_STATUS);
    stb.wrUpper  = regWrEn && (regAddr == OFS_UPPER);
    stb.txPush1  = regWrEn && (regAddr == OFS_TXB) && !quadMode && txHasRoom1;
    stb.txPush4  = regWrEn && (regAddr == OFS_TXW) &&  quadMode && txHasRoom4;
    stb.rxPop1   = regRdEn && (regAddr == OFS_RXB) && !quadMode && rxHasByte;
    stb.rxPop4   = regRdEn && (regAddr == OFS_RXW) &&  quadMode && rxHasWord;
    stb.txPop    = txReady && txHasByte;
    stb.rxPush   = rxValid && rxHasRoom;

    if (regRdEn) begin
      unique case (regAddr)
        OFS_CTRL:   stb.rdSel = RD_CTRL;
        OFS_FRAMES: stb.rdSel = RD_FRAMES;
        OFS_IEN:    stb.rdSel = RD_IEN;
        OFS_STATUS: stb.rdSel = RD_STATUS;
        OFS_UPPER:  stb.rdSel = RD_UPPER;
        OFS_RXB:    stb.rdSel = stb.rxPop1 ? RD_RXB : RD_NONE;
        OFS_RXW:    stb.rdSel = stb.rxPop4 ? RD_RXW : RD_NONE;
        default:    stb.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/spi_regfront_dp.sv
module spi_regfront_dp
  import spi_regfront_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic [7:0]       rxByte,
  input  logic             txDoneIn,
  input  logic             rxDoneIn,
  input  logic             engineReady,
  output logic [7:0]       txByte,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output logic [31:0]      ctrlReg,
  output logic [31:0]      framesReg,
  output logic [15:0]      upperReg,
  output logic             frameStart,
  output logic             irq
);

  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [IEN_W-1:0]    ienReg;
  logic [STICKY_W-1:0] sticky;
  logic [STICKY_W-1:0] stickySet;
  logic [STICKY_W-1:0] stickyClr;
  logic [31:0]         statusWord;
  logic [31:0]         txHead;
  logic [31:0]         rxHead;
  logic [2:0]          txPushN;
  logic [2:0]          txPopN;
  logic [2:0]          rxPushN;
  logic [2:0]          rxPopN;

  always_comb begin
    txPushN = stb.txPush4 ? 3'd4 : (stb.txPush1 ? 3'd1 : 3'd0);
    txPopN  = stb.txPop  ? 3'd1 : 3'd0;
    rxPushN = stb.rxPush ? 3'd1 : 3'd0;
    rxPopN  = stb.rxPop4 ? 3'd4 : (stb.rxPop1 ? 3'd1 : 3'd0);
  end

  spi_regfront_fifo #(.DEPTH(DEPTH)) txFifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (stb.wrFrames),
    .pushN    (txPushN),
    .pushData (regWrData),
    .popN     (txPopN),
    .headWord (txHead),
    .level    (txLevel)
  );

  spi_regfront_fifo #(.DEPTH(DEPTH)) rxFifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (stb.wrFrames),
    .pushN    (rxPushN),
    .pushData ({24'h0, rxByte}),
    .popN     (rxPopN),
    .headWord (rxHead),
    .level    (rxLevel)
  );

  assign txByte = txHead[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      framesReg  <= '0;
      upperReg   <= '0;
      ienReg     <= '0;
      frameStart <= 1'b0;
    end else begin
      if (stb.wrCtrl)   ctrlReg   <= regWrData & CTRL_WMASK;
      if (stb.wrFrames) framesReg <= regWrData;
      if (stb.wrUpper)  upperReg  <= regWrData[31:16];
      if (stb.wrIen)    ienReg    <= regWrData[IEN_W-1:0];
      frameStart <= stb.wrFrames;
    end
  end

  // Sticky events: bit0 tx done, bit1 rx done, bit2 rx available, bit3 tx available.
  always_comb begin
    stickySet = {stb.txPop, stb.rxPush, rxDoneIn, txDoneIn};
    stickyClr = stb.wrStatus ? regWrData[STICKY_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sticky <= '0;
    else       sticky <= (sticky & ~stickyClr) | stickySet;
  end

  always_comb begin
    statusWord = {23'h0, ctrlReg[QUAD_BIT], engineReady, 1'b0,
                  (txLevel == LVL_FULL), (rxLevel == '0), sticky};
    irq = |(statusWord[IEN_W-1:0] & ienReg);
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_CTRL:   regRdData = ctrlReg;
      RD_FRAMES: regRdData = framesReg;
      RD_IEN:    regRdData = {{(32-IEN_W){1'b0}}, ienReg};
      RD_STATUS: regRdData = statusWord;
      RD_UPPER:  regRdData = {upperReg, 16'h0};
      RD_RXB:    regRdData = {24'h0, rxHead[7:0]};
      RD_RXW:    regRdData = rxHead;
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/spi_host_regfront.sv
module spi_host_regfront
  import spi_regfront_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic [7:0]  txByte,
  output logic        txValid,
  input  logic        txReady,
  input  logic [7:0]  rxByte,
  input  logic        rxValid,
  input  logic        txDoneIn,
  input  logic        rxDoneIn,
  input  logic        engineReady,
  output logic        cfgEnable,
  output logic        cfgHost,
  output logic [3:0]  cfgClkDiv,
  output logic [1:0]  cfgLaneMode,
  output logic        cfgWideSel,
  output logic [31:0] cfgTotalBytes,
  output logic [8:0]  cfgCmdBytes,
  output logic        cfgMultiLane,
  output logic [3:0]  cfgIdleCycles,
  output logic [1:0]  cfgFrameFlags,
  output logic        frameStart,
  output logic        irq
);

  strobes_t         stb;
  logic [LVL_W-1:0] txLevel;
  logic [LVL_W-1:0] rxLevel;
  logic [31:0]      ctrlReg;
  logic [31:0]      framesReg;
  logic [15:0]      upperReg;

  spi_regfront_ctrl #(.DEPTH(FIFO_DEPTH)) ctrl_i (
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .quadMode (ctrlReg[QUAD_BIT]),
    .txReady  (txReady),
    .rxValid  (rxValid),
    .txLevel  (txLevel),
    .rxLevel  (rxLevel),
    .stb      (stb)
  );

  spi_regfront_dp #(.DEPTH(FIFO_DEPTH)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .rxByte      (rxByte),
    .txDoneIn    (txDoneIn),
    .rxDoneIn    (rxDoneIn),
    .engineReady (engineReady),
    .txByte      (txByte),
    .txLevel     (txLevel),
    .rxLevel     (rxLevel),
    .ctrlReg     (ctrlReg),
    .framesReg   (framesReg),
    .upperReg    (upperReg),
    .frameStart  (frameStart),
    .irq         (irq)
  );

  assign txValid       = (txLevel != '0);
  assign cfgEnable     = ctrlReg[0];
  assign cfgHost       = ctrlReg[1];
  assign cfgWideSel    = ctrlReg[13];
  assign cfgLaneMode   = ctrlReg[15:14];
  assign cfgClkDiv     = ctrlReg[27:24];
  assign cfgTotalBytes = {upperReg, framesReg[15:0]};
  assign cfgCmdBytes   = framesReg[24:16];
  assign cfgMultiLane  = framesReg[25];
  assign cfgIdleCycles = framesReg[29:26];
  assign cfgFrameFlags = framesReg[31:30];

endmodule

// File: rtl/spi_host_regfront_chk.sv
module spi_host_regfront_chk #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic [7:0]       regAddr,
  input logic [31:0]      regWrData,
  input logic [31:0]      regRdData,
  input logic             txValid,
  input logic             engineReady,
  input logic             frameStart,
  input logic             irq,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel
);

  assert_frame_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h04) |=> frameStart);

  assert_flush_R13: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (!txValid && rxLevel == '0));

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h0C && regWrData[5:0] == 6'h0) |=> !irq);

  assert_ready_bit_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 8'h10) |-> (regRdData[7] == engineReady));

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 8'h40 && rxLevel == '0) |-> (regRdData == 32'h0));

  assert_short_quad_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && regAddr == 8'h48 && rxLevel < LVL_W'(4))
      |=> (rxLevel >= $past(rxLevel)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LVL_W'(DEPTH)) && (rxLevel <= LVL_W'(DEPTH)));

endmodule

bind spi_host_regfront spi_host_regfront_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regRdEn     (regRdEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .txValid     (txValid),
  .engineReady (engineReady),
  .frameStart  (frameStart),
  .irq         (irq),
  .txLevel     (txLevel),
  .rxLevel     (rxLevel)
);

// File: tb/spi_host_regfront_tb_top.sv
module spi_host_regfront_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = 8'h0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic [7:0]  txByte;
  logic        txValid;
  logic        txReady = 1'b0;
  logic [7:0]  rxByte = 8'h0;
  logic        rxValid = 1'b0;
  logic        txDoneIn = 1'b0;
  logic        rxDoneIn = 1'b0;
  logic        engineReady = 1'b1;
  logic        cfgEnable;
  logic        cfgHost;
  logic [3:0]  cfgClkDiv;
  logic [1:0]  cfgLaneMode;
  logic        cfgWideSel;
  logic [31:0] cfgTotalBytes;
  logic [8:0]  cfgCmdBytes;
  logic        cfgMultiLane;
  logic [3:0]  cfgIdleCycles;
  logic [1:0]  cfgFrameFlags;
  logic        frameStart;
  logic        irq;

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  localparam logic [31:0] MODE_BYTE = 32'h0000_0003;
  localparam logic [31:0] MODE_QUAD = 32'h0001_0003;

  always #5 clk = ~clk;

  spi_host_regfront dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txByte(txByte), .txValid(txValid), .txReady(txReady),
    .rxByte(rxByte), .rxValid(rxValid), .txDoneIn(txDoneIn),
    .rxDoneIn(rxDoneIn), .engineReady(engineReady), .cfgEnable(cfgEnable),
    .cfgHost(cfgHost), .cfgClkDiv(cfgClkDiv), .cfgLaneMode(cfgLaneMode),
    .cfgWideSel(cfgWideSel), .cfgTotalBytes(cfgTotalBytes),
    .cfgCmdBytes(cfgCmdBytes), .cfgMultiLane(cfgMultiLane),
    .cfgIdleCycles(cfgIdleCycles), .cfgFrameFlags(cfgFrameFlags),
    .frameStart(frameStart), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rdReg(a, d);
    check(req, d, exp);
  endtask

  task automatic engPop(input string req, input logic [7:0] exp);
    @(negedge clk);
    txReady = 1'b1;
    #1 check(req, {23'h0, txValid, txByte}, {23'h0, 1'b1, exp});
    @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic engPush(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic clearSticky();
    wrReg(8'h10, 32'hF);
  endtask

  task automatic testReset();
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 txValid", {31'h0, txValid}, 32'h0);
    rdCheck("R1 control", 8'h00, 32'h0);
    rdCheck("R1 frames", 8'h04, 32'h0);
    rdCheck("R1 ien", 8'h0C, 32'h0);
    rdCheck("R1 upper", 8'h50, 32'h0);
    rdCheck("R1 status", 8'h10, 32'h90);
  endtask

  task automatic testControl();
    wrReg(8'h00, 32'hFFFF_FFFF);
    rdCheck("R2 masked readback", 8'h00, 32'h0F01_FC0F);
    check("R2 fields", {20'h0, cfgClkDiv, 1'b0, cfgLaneMode, cfgWideSel, 2'b0, cfgHost, cfgEnable},
          {20'h0, 4'hF, 1'b0, 2'b11, 1'b1, 2'b0, 1'b1, 1'b1});
    wrReg(8'h00, 32'h0500_4002);
    check("R2 fields second", {20'h0, cfgClkDiv, 1'b0, cfgLaneMode, cfgWideSel, 2'b0, cfgHost, cfgEnable},
          {20'h0, 4'h5, 1'b0, 2'b01, 1'b0, 2'b0, 1'b1, 1'b0});
    wrReg(8'h00, MODE_BYTE);
  endtask

  task automatic testFrames();
    wrReg(8'h50, 32'h0003_ABCD);
    rdCheck("R3 upper readback", 8'h50, 32'h0003_0000);
    wrReg(8'h04, 32'h960A_1234);
    check("R3 frameStart high", {31'h0, frameStart}, 32'h1);
    check("R3 total", cfgTotalBytes, 32'h0003_1234);
    check("R3 fields", {16'h0, cfgFrameFlags, cfgIdleCycles, cfgMultiLane, cfgCmdBytes},
          {16'h0, 2'b10, 4'h5, 1'b1, 9'h00A});
    @(negedge clk);
    check("R3 frameStart one cycle", {31'h0, frameStart}, 32'h0);
    rdCheck("R3 frames readback", 8'h04, 32'h960A_1234);
  endtask

  task automatic testByteTx();
    wrReg(8'h00, MODE_BYTE);
    wrReg(8'h44, 32'hFFFF_FFA1);
    wrReg(8'h44, 32'h0000_12B2);
    wrReg(8'h44, 32'h0000_00C3);
    engPop("R4 byte0", 8'hA1);
    engPop("R4 byte1", 8'hB2);
    engPop("R4 byte2", 8'hC3);
    check("R4 drained", {31'h0, txValid}, 32'h0);
  endtask

  task automatic testQuadTx();
    wrReg(8'h00, MODE_QUAD);
    wrReg(8'h4C, 32'h4433_2211);
    engPop("R5 word b0", 8'h11);
    engPop("R5 word b1", 8'h22);
    engPop("R5 word b2", 8'h33);
    engPop("R5 word b3", 8'h44);
    check("R5 drained", {31'h0, txValid}, 32'h0);
  endtask

  task automatic testTxFull();
    logic [31:0] st;
    wrReg(8'h00, MODE_BYTE);
    for (int i = 0; i < 14; i++) wrReg(8'h44, 32'(i));
    wrReg(8'h00, MODE_QUAD);
    wrReg(8'h4C, 32'hDDCC_BBAA);   // only two slots free: refused whole (R5)
    wrReg(8'h00, MODE_BYTE);
    wrReg(8'h44, 32'd14);
    wrReg(8'h44, 32'd15);
    rdReg(8'h10, st);
    check("R11 tx full bit", {31'h0, st[5]}, 32'h1);
    wrReg(8'h44, 32'h99);          // full: dropped (R9)
    for (int i = 0; i < 16; i++) engPop("R9 R5 tx order after drops", 8'(i));
    check("R9 nothing extra", {31'h0, txValid}, 32'h0);
  endtask

  task automatic testByteRx();
    logic [31:0] st;
    wrReg(8'h00, MODE_BYTE);
    engPush(8'h5A);
    engPush(8'h6B);
    rdReg(8'h10, st);
    check("R11 rx not empty", {31'h0, st[4]}, 32'h0);
    rdCheck("R6 rx byte0", 8'h40, 32'h5A);
    rdCheck("R6 rx byte1", 8'h40, 32'h6B);
    rdCheck("R6 empty read", 8'h40, 32'h0);
    rdReg(8'h10, st);
    check("R11 rx empty", {31'h0, st[4]}, 32'h1);
  endtask

  task automatic testQuadRx();
    wrReg(8'h00, MODE_QUAD);
    engPush(8'hA0);
    engPush(8'hB1);
    engPush(8'hC2);
    rdCheck("R7 short quad read", 8'h48, 32'h0);
    engPush(8'hD3);
    rdCheck("R7 quad word", 8'h48, 32'hD3C2_B1A0);
    rdCheck("R7 quad empty", 8'h48, 32'h0);
  endtask

  task automatic testModeSelect();
    logic [31:0] st;
    wrReg(8'h00, MODE_QUAD);
    rdReg(8'h10, st);
    check("R11 quad mirror", {31'h0, st[8]}, 32'h1);
    engPush(8'h3C);
    rdCheck("R8 byte read in quad mode", 8'h40, 32'h0);
    wrReg(8'h44, 32'h77);
    check("R8 byte write in quad mode", {31'h0, txValid}, 32'h0);
    wrReg(8'h00, MODE_BYTE);
    rdReg(8'h10, st);
    check("R11 byte mirror", {31'h0, st[8]}, 32'h0);
    wrReg(8'h4C, 32'h1234_5678);
    check("R8 quad write in byte mode", {31'h0, txValid}, 32'h0);
    rdCheck("R8 quad read in byte mode", 8'h48, 32'h0);
    rdCheck("R8 byte kept", 8'h40, 32'h3C);
  endtask

  task automatic testRxOverflow();
    wrReg(8'h00, MODE_BYTE);
    for (int i = 0; i < 17; i++) engPush(8'(8'h20 + i));
    for (int i = 0; i < 16; i++) rdCheck("R9 rx order", 8'h40, 32'(8'h20 + i));
    rdCheck("R9 17th dropped", 8'h40, 32'h0);
  endtask

  task automatic testStickyIrq();
    clearSticky();
    wrReg(8'h0C, 32'h0);
    rdCheck("R10 cleared", 8'h10, 32'h90);
    @(negedge clk); txDoneIn = 1'b1;
    @(negedge clk); txDoneIn = 1'b0;
    rdCheck("R10 tx done sticky", 8'h10, 32'h91);
    check("R12 masked", {31'h0, irq}, 32'h0);
    wrReg(8'h0C, 32'h01);
    check("R12 enabled", {31'h0, irq}, 32'h1);
    wrReg(8'h10, 32'h1);
    check("R12 cleared irq", {31'h0, irq}, 32'h0);
    rdCheck("R10 w1c", 8'h10, 32'h90);
    @(negedge clk); rxDoneIn = 1'b1;
    @(negedge clk); rxDoneIn = 1'b0;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'h10; regWrData = 32'h2; rxDoneIn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; rxDoneIn = 1'b0;
    rdCheck("R10 set wins over clear", 8'h10, 32'h92);
    wrReg(8'h0C, 32'h04);
    check("R12 other bit", {31'h0, irq}, 32'h0);
    engPush(8'h01);
    check("R12 rx available irq", {31'h0, irq}, 32'h1);
    rdCheck("R10 rx available", 8'h10, 32'h86);
    wrReg(8'h0C, 32'h0);
    check("R12 disable", {31'h0, irq}, 32'h0);
  endtask

  task automatic testFlush();
    logic [31:0] st;
    wrReg(8'h00, MODE_BYTE);
    wrReg(8'h44, 32'h77);
    engPush(8'h88);
    wrReg(8'h04, 32'h0000_0001);
    check("R13 tx flushed", {31'h0, txValid}, 32'h0);
    rdReg(8'h10, st);
    check("R13 rx flushed", {31'h0, st[4]}, 32'h1);
    rdCheck("R13 rx read after flush", 8'h40, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testControl();
    testFrames();
    testByteTx();
    testQuadTx();
    testTxFull();
    testByteRx();
    testQuadRx();
    testModeSelect();
    testRxOverflow();
    testStickyIrq();
    testFlush();
    finished = 1'b1;
  end

  initial begin
    int cycles = 0;
    while (!finished && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule